// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Counter

This block holds the main and swallow counters that sit behind an external two-ratio prescaler (divide by P or by P+1). It is clocked by the prescaler output. At the start of every period it loads the main count B and the swallow count A. It asks the prescaler for the larger ratio P+1 during the first A prescaler cycles, and for the ratio P during the rest of the B cycles. The fast input clock is therefore divided by N = P·B + A overall, and one step of A moves N by exactly one.

New B and A values arrive through a single-cycle parallel write. A write is accepted only when B is at least the minimum main count and A does not exceed B. Accepted values wait in a holding register until the running period ends, so a period never mixes old and new settings. A rejected write leaves the held values untouched and raises a one-cycle reject flag. Widths, reset values, the minimum main count and the polarity of the modulus line are parameters.

Top module: `pulse_swallow_counter`

## Requirements
- R1: Each period lasts exactly B prescaler cycles, and the modulus line requests P+1 in exactly A of them, so the fast clock is divided by P·B + A.
- R2: The P+1 request is asserted from the first cycle of a period for A consecutive cycles and is then released. With A = 0 it is never asserted in that period. With A = B it is asserted for the whole period.
- R3: Once the P+1 request has been released inside a period, it stays released until that period ends.
- R4: `div_pulse` is high for exactly one cycle, the last cycle of each period, so consecutive pulses are B cycles apart.
- R5: A write accepted in the middle of a period does not change that period. Both counters pick up the new values at the next reload.
- R6: A write with A > B or B < 3 is rejected: `cfg_reject` is high in the cycle after the write, and the previously held B and A stay in use. An accepted write leaves `cfg_reject` low.
- R7: A write accepted in the last cycle of a period is used by the reload at the end of that same cycle.
- R8: While reset is held, and in the first cycle after it, `div_pulse` and `cfg_reject` are low. The first period uses the reset values RST_B = 16 and RST_A = 5.
- R9: With the default MC_ACTIVE_HIGH = 1, `mod_sel` = 1 selects P+1 and `mod_sel` = 0 selects P. With MC_ACTIVE_HIGH = 0 the line is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for new B and A |
| cfg_b | input | B_W (12) | Main count B to write |
| cfg_a | input | A_W (6) | Swallow count A to write |
| mod_sel | output | 1 | Prescaler modulus request (P+1 when active) |
| div_pulse | output | 1 | One-cycle pulse ending each N period |
| cfg_reject | output | 1 | Previous-cycle write was rejected |

## Verification
A configuration write and the end-of-period reload can land in the same cycle. In that case the freshly accepted values must feed the reload that happens in that cycle.

The bench provokes this by watching for `div_pulse` at a falling edge and raising the write strobe at that same falling edge. It then counts the following period in prescaler cycles and in modelled fast-clock cycles, and expects the new B and P·B + A. A second directed case writes one cycle after a pulse. That case must leave the running period at the old N and move to the new N one period later.

// File: rtl/swc_pkg.sv
package swc_pkg;

   localparam int SWC_B_W_DEF = 12;
   localparam int SWC_A_W_DEF = 6;
   localparam int SWC_B_MIN   = 3;

   // A setting is usable when the main count reaches its minimum and the
   // swallow count fits inside the main count.
   function automatic logic cfg_ok(input int unsigned b,
                                   input int unsigned a,
                                   input int unsigned b_min);
      return (b >= b_min) && (a <= b);
   endfunction

endpackage

// File: rtl/swc_dcount.sv
module swc_dcount #(
   parameter int W        = 8,
   parameter int RST_VAL  = 0,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         zero
);

   localparam logic [W-1:0] RV = W'(RST_VAL);

   logic [W-1:0] cnt_dec;

   generate
      if (SATURATE) begin : g_sat
         // parks at zero until the next load
         assign cnt_dec = (cnt == '0) ? '0 : cnt - W'(1);
      end else begin : g_wrap
         assign cnt_dec = cnt - W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= RV;
      else if (load)
         cnt <= load_val;
      else
         cnt <= cnt_dec;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/swc_cfg.sv
module swc_cfg #(
   parameter int B_W   = 12,
   parameter int A_W   = 6,
   parameter int B_MIN = 3,
   parameter int RST_B = 16,
   parameter int RST_A = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [B_W-1:0] b_in,
   input  logic [A_W-1:0] a_in,
   output logic [B_W-1:0] nxt_b,
   output logic [A_W-1:0] nxt_a,
   output logic           reject
);

   logic [B_W-1:0] hold_b;
   logic [A_W-1:0] hold_a;
   logic           ok;
   logic           take;

   assign ok   = swc_pkg::cfg_ok(32'(b_in), 32'(a_in), 32'(B_MIN));
   assign take = we & ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_b <= B_W'(RST_B);
         hold_a <= A_W'(RST_A);
         reject <= 1'b0;
      end else begin
         if (take) begin
            hold_b <= b_in;
            hold_a <= a_in;
         end
         reject <= we & ~ok;
      end
   end

   // bypass: a write accepted in the reload cycle feeds that reload
   assign nxt_b = take ? b_in : hold_b;
   assign nxt_a = take ? a_in : hold_a;

endmodule

// File: rtl/pulse_swallow_counter.sv
module pulse_swallow_counter #(
   parameter int B_W            = swc_pkg::SWC_B_W_DEF,
   parameter int A_W            = swc_pkg::SWC_A_W_DEF,
   parameter int B_MIN          = swc_pkg::SWC_B_MIN,
   parameter int RST_B          = 16,
   parameter int RST_A          = 5,
   parameter bit MC_ACTIVE_HIGH = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [B_W-1:0] cfg_b,
   input  logic [A_W-1:0] cfg_a,
   output logic           mod_sel,
   output logic           div_pulse,
   output logic           cfg_reject
);

   localparam int B_MAX = (1 << B_W) - 1;

   generate
      if (B_MIN < 2 || B_MIN > B_MAX) begin : g_bad_min
         $error("B_MIN outside usable range");
      end
      if (RST_B < B_MIN || RST_B > B_MAX || RST_A > RST_B || RST_A < 0) begin : g_bad_rst
         $error("reset setting violates A <= B and B >= B_MIN");
      end
      if (A_W > B_W) begin : g_bad_w
         $error("swallow width exceeds main width");
      end
   endgenerate

   logic [B_W-1:0] nxt_b;
   logic [A_W-1:0] nxt_a;
   logic [B_W-1:0] b_load;
   logic [B_W-1:0] b_cnt;
   logic [A_W-1:0] a_cnt;
   logic           b_zero;
   logic           a_zero;

   swc_cfg #(
      .B_W  (B_W),
      .A_W  (A_W),
      .B_MIN(B_MIN),
      .RST_B(RST_B),
      .RST_A(RST_A)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .b_in  (cfg_b),
      .a_in  (cfg_a),
      .nxt_b (nxt_b),
      .nxt_a (nxt_a),
      .reject(cfg_reject)
   );

   assign b_load = nxt_b - B_W'(1);

   // main counter: B-1 down to 0, reloads on its own terminal count
   swc_dcount #(
      .W       (B_W),
      .RST_VAL (RST_B - 1),
      .SATURATE(1'b0)
   ) u_bcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (b_zero),
      .load_val(b_load),
      .cnt     (b_cnt),
      .zero    (b_zero)
   );

   // swallow counter: A down to 0, then holds until the period ends
   swc_dcount #(
      .W       (A_W),
      .RST_VAL (RST_A),
      .SATURATE(1'b1)
   ) u_acnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (b_zero),
      .load_val(nxt_a),
      .cnt     (a_cnt),
      .zero    (a_zero)
   );

   generate
      if (MC_ACTIVE_HIGH) begin : g_mc_hi
         assign mod_sel = ~a_zero;
      end else begin : g_mc_lo
         assign mod_sel = a_zero;
      end
   endgenerate

   assign div_pulse = b_zero;

endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
   parameter int B_W            = 12,
   parameter int A_W            = 6,
   parameter int B_MIN          = 3,
   parameter bit MC_ACTIVE_HIGH = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cfg_we,
   input logic [B_W-1:0] cfg_b,
   input logic [A_W-1:0] cfg_a,
   input logic           mod_sel,
   input logic           div_pulse,
   input logic           cfg_reject
);

   logic mc_act;
   logic bad_wr;

   assign mc_act = MC_ACTIVE_HIGH ? mod_sel : ~mod_sel;
   assign bad_wr = cfg_we && ((32'(cfg_a) > 32'(cfg_b)) || (32'(cfg_b) < B_MIN));

   p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   p_mod_stays_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mc_act && !div_pulse) |=> !mc_act);

   p_reject_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> cfg_reject);

   p_accept_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !bad_wr) |=> !cfg_reject);

   p_no_spurious_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> !cfg_reject);

   p_reset_quiet_r8: assert property (@(posedge clk)
      !rst_n |=> (!div_pulse && !cfg_reject));

endmodule

bind pulse_swallow_counter swc_chk #(
   .B_W           (B_W),
   .A_W           (A_W),
   .B_MIN         (B_MIN),
   .MC_ACTIVE_HIGH(MC_ACTIVE_HIGH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_b     (cfg_b),
   .cfg_a     (cfg_a),
   .mod_sel   (mod_sel),
   .div_pulse (div_pulse),
   .cfg_reject(cfg_reject)
);

// File: tb/pulse_swallow_counter_bench.sv
module pulse_swallow_counter_bench;

   localparam int P      = 8;      // modelled prescaler ratio
   localparam int HALF   = 10;     // 50 MHz clock
   localparam int NV     = 10;
   localparam int RST_B  = 16;
   localparam int RST_A  = 5;

   localparam int TB_B [NV] = '{3, 3, 16, 100, 5, 63, 4095, 2, 10, 4095};
   localparam int TB_A [NV] = '{0, 3, 5, 63, 6, 63, 0, 0, 1, 63};
   localparam bit TB_OK[NV] = '{1, 1, 1, 1, 0, 1, 1, 0, 1, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_b = '0;
   logic [5:0]  cfg_a = '0;
   logic        mod_sel;
   logic        div_pulse;
   logic        cfg_reject;

   int n_chk = 0;
   int n_bad = 0;

   always #HALF clk = ~clk;

   pulse_swallow_counter u_pulse_swallow_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_b     (cfg_b),
      .cfg_a     (cfg_a),
      .mod_sel   (mod_sel),
      .div_pulse (div_pulse),
      .cfg_reject(cfg_reject)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (!div_pulse);
   endtask

   // from a pulse cycle, count the next full period
   task automatic measure(output int cyc, output int fast, output int hi);
      cyc = 0; fast = 0; hi = 0;
      do begin
         @(negedge clk);
         cfg_we = 1'b0;
         cyc++;
         fast += mod_sel ? P + 1 : P;
         if (mod_sel) hi++;
      end while (!div_pulse);
   endtask

   task automatic write_cfg(input int b, input int a);
      @(negedge clk);
      cfg_we = 1'b1; cfg_b = 12'(b); cfg_a = 6'(a);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic check_period(input int eb, input int ea, input string tag);
      int cyc, fast, hi;
      measure(cyc, fast, hi);
      check(cyc == eb, {tag, " R4 period length"}, cyc, eb);
      check(hi == ea, {tag, " R2 P+1 cycles"}, hi, ea);
      check(fast == P * eb + ea, {tag, " R1 total N"}, fast, P * eb + ea);
   endtask

   initial begin
      #(2 * HALF * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int cur_b, cur_a;
      int cyc, fast, hi;

      // R8: reset state
      repeat (3) @(negedge clk);
      check(div_pulse == 1'b0, "R8 pulse in reset", int'(div_pulse), 0);
      check(cfg_reject == 1'b0, "R8 reject in reset", int'(cfg_reject), 0);
      rst_n = 1'b1;
      check(mod_sel == 1'b1, "R9 first cycle requests P+1", int'(mod_sel), 1);
      check(div_pulse == 1'b0, "R8 pulse after reset", int'(div_pulse), 0);
      wait_pulse();
      check_period(RST_B, RST_A, "reset values");
      cur_b = RST_B; cur_a = RST_A;

      // table walk
      for (int i = 0; i < NV; i++) begin
         write_cfg(TB_B[i], TB_A[i]);
         check(cfg_reject == !TB_OK[i], $sformatf("R6 reject flag entry %0d", i),
               int'(cfg_reject), int'(!TB_OK[i]));
         if (TB_OK[i]) begin cur_b = TB_B[i]; cur_a = TB_A[i]; end
         wait_pulse();
         check_period(cur_b, cur_a, $sformatf("entry %0d", i));
      end

      // R7: write coincides with the reload cycle
      write_cfg(16, 5);
      wait_pulse();
      wait_pulse();
      cfg_we = 1'b1; cfg_b = 12'd20; cfg_a = 6'd7;
      check_period(20, 7, "R7 write in reload cycle");

      // R5: write one cycle into a period keeps the old period
      wait_pulse();
      @(negedge clk);
      cfg_we = 1'b1; cfg_b = 12'd9; cfg_a = 6'd2;
      cyc = 1; fast = mod_sel ? P + 1 : P; hi = mod_sel ? 1 : 0;
      do begin
         @(negedge clk);
         cfg_we = 1'b0;
         cyc++;
         fast += mod_sel ? P + 1 : P;
         if (mod_sel) hi++;
      end while (!div_pulse);
      check(fast == P * 20 + 7, "R5 running period unchanged", fast, P * 20 + 7);
      check(cyc == 20, "R5 running period length", cyc, 20);
      check_period(9, 2, "R5 next period new values");

      // R8: mid-run reset restores defaults and drops the held setting
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(div_pulse == 1'b0, "R8 pulse during reset", int'(div_pulse), 0);
      rst_n = 1'b1;
      wait_pulse();
      check_period(RST_B, RST_A, "R8 defaults after reset");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule